// File: doc/BRIEF.md
# Output Window Monitor with Power-Good

This block supervises a regulated output rail using four digital comparator flags. It drives an active-low power-good indicator. Overvoltage and undervoltage are each judged against a pair of thresholds. The outer threshold of the pair sets the fault, and the inner threshold releases it. A fault is recognised only after its condition has lasted a programmable number of 1 µs ticks, so short spikes are ignored. The two fault flags only report. They never turn the rail off, and any shutdown decision belongs to the mode controller.

Power-good is asserted (low) only after a full start-up. A start-up-complete strobe, given while no fault is present, starts a long delay counted in ticks. When that delay expires, `pg_n` goes low. Any active fault releases `pg_n` high. When a window fault clears, `pg_n` returns low at once, without a second delay. Dropping the run qualifier clears all state and holds `pg_n` high.

Flag encoding: `ov_above_hi` is 1 while the output is above the upper (setting) overvoltage threshold, and `ov_above_lo` is 1 while it is above the lower (releasing) overvoltage threshold. `uv_below_lo` is 1 while the output is below the lower (setting) undervoltage threshold, and `uv_below_hi` is 1 while it is below the upper (releasing) undervoltage threshold.

Top module: `out_window_pg`

## Requirements
- R1: `ov_fault` rises at the clock edge that samples the FILT_TICKS-th tick of an unbroken run of cycles with `ov_above_hi`=1. It stays 0 before that edge.
- R2: Any cycle with the setting flag at 0 (`ov_above_hi` or `uv_below_lo`) while no fault is present restarts that fault's tick count from zero.
- R3: A set `ov_fault` stays 1 while `ov_above_lo`=1, even when `ov_above_hi` has gone to 0. It clears at the first edge that samples `ov_above_lo`=0.
- R4: `uv_fault` rises at the edge that samples the FILT_TICKS-th tick of an unbroken run of cycles with `uv_below_lo`=1.
- R5: A set `uv_fault` stays 1 while `uv_below_hi`=1. It clears at the first edge that samples `uv_below_hi`=0.
- R6: After reset, `pg_n`=1, `ov_fault`=0 and `uv_fault`=0.
- R7: A `startup_done` pulse sampled with no fault active starts the power-good delay. `pg_n` falls at the edge that samples the DELAY_TICKS-th tick after that pulse.
- R8: A fault that appears while the delay is running cancels the delay. Only a new `startup_done` pulse, sampled with no fault active, starts it again.
- R9: While `ov_fault` or `uv_fault` is 1, `pg_n` is 1.
- R10: Once the delay has completed, clearing every fault returns `pg_n` to 0 in the same cycle, with no new delay.
- R11: An edge that samples `run_en`=0 clears both filters, both faults and the delay progress, and leaves `pg_n`=1.
- R12: A `startup_done` pulse sampled while a fault is active is ignored. `pg_n` stays 1 and no delay starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| run_en | input | 1 | Run qualifier; low clears all state |
| startup_done | input | 1 | Strobe marking the end of the rail's soft start |
| ov_above_hi | input | 1 | Output above the setting overvoltage threshold |
| ov_above_lo | input | 1 | Output above the releasing overvoltage threshold |
| uv_below_lo | input | 1 | Output below the setting undervoltage threshold |
| uv_below_hi | input | 1 | Output below the releasing undervoltage threshold |
| ov_fault | output | 1 | Filtered overvoltage fault |
| uv_fault | output | 1 | Filtered undervoltage fault |
| pg_n | output | 1 | Power-good, active low |

## Verification
The hardest case to reach is a fault that turns up partway through the power-good delay. Hitting it needs a strobe at a moment with no fault, and then a level excursion that lasts just long enough to pass the persistence filter before the delay expires. Directed sequences place this case, the hysteresis band between each pair of thresholds, and a filter run broken one tick short. A random walk over five rail levels, with sparse strobes, gapped ticks and occasional loss of the run qualifier, then exercises the mixed orderings, and a bench reference model checks every cycle.

// File: rtl/wmon_pkg.sv
package wmon_pkg;

  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_DELAY = 2'd1,
    PG_READY = 2'd2
  } pg_state_e;

  // True when this tick completes a run of n qualifying ticks.
  function automatic logic run_done(input int unsigned cnt, input logic cond,
                                    input logic tick, input int unsigned n);
    return cond && tick && (cnt == n - 1);
  endfunction

  // Next count of a run counter that restarts whenever cond is low.
  function automatic int unsigned run_next(input int unsigned cnt, input logic cond,
                                           input logic tick, input int unsigned n);
    if (!cond) return 0;
    if (!tick) return cnt;
    if (cnt == n - 1) return 0;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/wmon_filter.sv
module wmon_filter #(
  parameter int unsigned FILT_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tick,
  input  logic trip,
  input  logic hold,
  output logic fault
);
  import wmon_pkg::*;

  localparam int unsigned CW = $clog2(FILT_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q;
  logic          set_ev;
  logic          release_ev;

  assign set_ev     = run_en && !fault_q && run_done(int'(cnt_q), trip, tick, FILT_TICKS);
  assign release_ev = run_en && fault_q && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!run_en) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (fault_q) begin
      cnt_q <= '0;
      if (release_ev) fault_q <= 1'b0;
    end else begin
      cnt_q <= CW'(run_next(int'(cnt_q), trip, tick, FILT_TICKS));
      if (set_ev) fault_q <= 1'b1;
    end
  end

  assign fault = fault_q;

  p_set_needs_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(trip && tick && run_en));
  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && hold && run_en) |=> fault_q);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !hold) |=> !fault_q);
  p_run_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!fault_q && cnt_q == '0));
  p_break_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && !fault_q) |=> (cnt_q == '0));

endmodule

// File: rtl/wmon_pgctl.sv
module wmon_pgctl #(
  parameter int unsigned DELAY_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tick,
  input  logic startup_done,
  input  logic fault_any,
  output logic pg_n
);
  import wmon_pkg::*;

  localparam int unsigned DW = $clog2(DELAY_TICKS + 1);

  pg_state_e     st_q, st_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          delay_start;
  logic          delay_cancel;
  logic          delay_done;

  assign delay_start  = (st_q == PG_IDLE) && startup_done && !fault_any;
  assign delay_cancel = (st_q == PG_DELAY) && fault_any;
  assign delay_done   = (st_q == PG_DELAY) && !fault_any &&
                        run_done(int'(dcnt_q), 1'b1, tick, DELAY_TICKS);

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    unique case (st_q)
      PG_IDLE: if (delay_start) begin
        st_d   = PG_DELAY;
        dcnt_d = '0;
      end
      PG_DELAY: begin
        if (delay_cancel) begin
          st_d   = PG_IDLE;
          dcnt_d = '0;
        end else if (delay_done) begin
          st_d   = PG_READY;
          dcnt_d = '0;
        end else begin
          dcnt_d = DW'(run_next(int'(dcnt_q), 1'b1, tick, DELAY_TICKS));
        end
      end
      default: st_d = PG_READY;
    endcase
    if (!run_en) begin
      st_d   = PG_IDLE;
      dcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PG_IDLE;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign pg_n = !((st_q == PG_READY) && !fault_any);

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    delay_cancel |=> (st_q == PG_IDLE));
  p_ready_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == PG_READY) |-> $past(tick && run_en && !fault_any));
  p_ignore_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PG_IDLE && fault_any) |=> (st_q == PG_IDLE));
  p_run_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> pg_n);

endmodule

// File: rtl/out_window_pg.sv
module out_window_pg #(
  parameter int unsigned FILT_TICKS  = 20,
  parameter int unsigned DELAY_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic run_en,
  input  logic startup_done,
  input  logic ov_above_hi,
  input  logic ov_above_lo,
  input  logic uv_below_lo,
  input  logic uv_below_hi,
  output logic ov_fault,
  output logic uv_fault,
  output logic pg_n
);

  logic ov_flt;
  logic uv_flt;
  logic fault_any;

  wmon_filter #(.FILT_TICKS(FILT_TICKS)) u_ov (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick_us),
    .trip(ov_above_hi), .hold(ov_above_lo), .fault(ov_flt)
  );

  wmon_filter #(.FILT_TICKS(FILT_TICKS)) u_uv (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick_us),
    .trip(uv_below_lo), .hold(uv_below_hi), .fault(uv_flt)
  );

  assign fault_any = ov_flt || uv_flt;

  wmon_pgctl #(.DELAY_TICKS(DELAY_TICKS)) u_pg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick_us),
    .startup_done(startup_done), .fault_any(fault_any), .pg_n(pg_n)
  );

  assign ov_fault = ov_flt;
  assign uv_fault = uv_flt;

  p_fault_releases_pg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flt || uv_flt) |-> pg_n);
  p_uv_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flt) |-> $past(uv_below_lo && tick_us));

endmodule

// File: tb/tb_out_window_pg.sv
module tb_out_window_pg;
  localparam int FT = 4;
  localparam int DT = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tk = 1'b0, run = 1'b0, sd = 1'b0;
  int   lvl = 2;   // 0 below UV lo, 1 UV band, 2 normal, 3 OV band, 4 above OV hi
  logic ov_hi, ov_lo, uv_lo, uv_hi;
  logic ov_f, uv_f, pg_n;

  assign ov_hi = (lvl >= 4);
  assign ov_lo = (lvl >= 3);
  assign uv_lo = (lvl <= 0);
  assign uv_hi = (lvl <= 1);

  always #2 clk = ~clk;

  out_window_pg #(.FILT_TICKS(FT), .DELAY_TICKS(DT)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tk), .run_en(run), .startup_done(sd),
    .ov_above_hi(ov_hi), .ov_above_lo(ov_lo), .uv_below_lo(uv_lo), .uv_below_hi(uv_hi),
    .ov_fault(ov_f), .uv_fault(uv_f), .pg_n(pg_n)
  );

  int vec = 0, bad = 0;
  string tag = "R6";

  // reference model
  int  m_oc = 0, m_uc = 0, m_st = 0, m_dc = 0;
  bit  m_of = 0, m_uf = 0;

  function automatic bit exp_pg();
    return !(m_st == 2 && !m_of && !m_uf);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit any;
      any = m_of || m_uf;
      if (!run) begin
        m_oc = 0; m_uc = 0; m_of = 0; m_uf = 0; m_st = 0; m_dc = 0;
      end else begin
        case (m_st)
          0: if (sd && !any) begin m_st = 1; m_dc = 0; end
          1: if (any) begin m_st = 0; m_dc = 0; end
             else if (tk) begin
               if (m_dc == DT - 1) begin m_st = 2; m_dc = 0; end else m_dc++;
             end
          default: ;
        endcase
        if (m_of) begin m_oc = 0; if (!ov_lo) m_of = 0; end
        else if (!ov_hi) m_oc = 0;
        else if (tk) begin if (m_oc == FT - 1) begin m_of = 1; m_oc = 0; end else m_oc++; end
        if (m_uf) begin m_uc = 0; if (!uv_hi) m_uf = 0; end
        else if (!uv_lo) m_uc = 0;
        else if (tk) begin if (m_uc == FT - 1) begin m_uf = 1; m_uc = 0; end else m_uc++; end
      end
    end
  end

  task automatic chk(input string t, input string what, input logic act, input logic expv);
    vec++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", t, what, act, expv, $time);
    end
  endtask

  task automatic cmp_all();
    chk(tag, "ov_fault", ov_f, m_of);
    chk(tag, "uv_fault", uv_f, m_uf);
    chk(tag, "pg_n", pg_n, exp_pg());
  endtask

  // one cycle: drive at negedge, compare at the following negedge
  task automatic cyc(input int l, input logic t, input logic s);
    lvl = l; tk = t; sd = s;
    @(negedge clk);
    cmp_all();
    sd = 1'b0;
  endtask

  task automatic ticks(input int l, input int n);
    for (int i = 0; i < n; i++) cyc(l, 1'b1, 1'b0);
  endtask

  task automatic reach_ready();
    run = 1'b1;
    cyc(2, 1'b1, 1'b1);
    ticks(2, DT);
  endtask

  initial begin : watchdog
    #400000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R6"; chk("R6", "pg_n after reset", pg_n, 1'b1);
    chk("R6", "ov_fault after reset", ov_f, 1'b0);
    chk("R6", "uv_fault after reset", uv_f, 1'b0);

    // R7: start-up delay
    tag = "R7"; run = 1'b1;
    cyc(2, 1'b1, 1'b1);
    ticks(2, DT - 1);
    chk("R7", "pg_n one tick before delay end", pg_n, 1'b1);
    ticks(2, 1);
    chk("R7", "pg_n after delay", pg_n, 1'b0);

    // R1 / R9: OV filter with gaps in ticks
    tag = "R1";
    ticks(4, FT - 1);
    cyc(4, 1'b0, 1'b0);
    chk("R1", "ov_fault one tick short", ov_f, 1'b0);
    ticks(4, 1);
    chk("R1", "ov_fault after full run", ov_f, 1'b1);
    chk("R9", "pg_n during ov fault", pg_n, 1'b1);

    // R3 / R10: hysteresis band holds, release restores pg without delay
    tag = "R3";
    ticks(3, 3);
    chk("R3", "ov_fault held in band", ov_f, 1'b1);
    ticks(2, 1);
    chk("R3", "ov_fault released", ov_f, 1'b0);
    chk("R10", "pg_n immediate recovery", pg_n, 1'b0);

    // R2: broken run restarts the count
    tag = "R2";
    ticks(0, FT - 1);
    ticks(2, 1);
    ticks(0, FT - 1);
    chk("R2", "uv_fault after broken run", uv_f, 1'b0);

    // R4 / R5
    tag = "R4";
    ticks(0, 1);
    chk("R4", "uv_fault set", uv_f, 1'b1);
    tag = "R5";
    ticks(1, 2);
    chk("R5", "uv_fault held in band", uv_f, 1'b1);
    ticks(2, 1);
    chk("R5", "uv_fault released", uv_f, 1'b0);
    chk("R10", "pg_n after uv recovery", pg_n, 1'b0);

    // R11: run low clears everything
    tag = "R11";
    ticks(4, FT);
    cyc(4, 1'b1, 1'b0);
    run = 1'b0;
    cyc(4, 1'b1, 1'b0);
    chk("R11", "ov_fault cleared by run low", ov_f, 1'b0);
    chk("R11", "pg_n high with run low", pg_n, 1'b1);
    run = 1'b1;
    ticks(2, DT + 2);
    chk("R11", "pg_n needs new start-up", pg_n, 1'b1);

    // R8: fault during delay cancels
    tag = "R8";
    cyc(2, 1'b1, 1'b1);
    ticks(2, 3);
    ticks(0, FT);
    ticks(2, DT + 2);
    chk("R8", "pg_n after cancelled delay", pg_n, 1'b1);

    // R12: strobe while fault ignored
    tag = "R12";
    ticks(4, FT);
    cyc(3, 1'b1, 1'b1);
    ticks(2, DT + 2);
    chk("R12", "pg_n strobe during fault", pg_n, 1'b1);
    reach_ready();
    chk("R7", "pg_n after fresh start-up", pg_n, 1'b0);

    // random phase
    tag = "R9";
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 12 && lvl > 0) lvl--;
      else if (r < 24 && lvl < 4) lvl++;
      else if (r < 30) lvl = 2;
      run = ($urandom_range(0, 299) != 0);
      cyc(lvl, ($urandom_range(0, 3) != 0), ($urandom_range(0, 59) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule